// File: doc/BRIEF.md
# Multiplexed CAM Bus Master

This block runs one single-byte read or write at a time on an 8-bit multiplexed address/data bus toward a conditional-access module interface chip. The host hands it a request through a valid/ready handshake. The request holds a direction bit, a 16-bit address, a write byte and a one-bit device index. The block sends the address as two byte phases over the shared data lines. Each byte is captured by the device on its own active-high latch strobe. For a read the block then releases the data lines; for a write it drives the write byte on them.

Next the block pulls the selected active-low chip select, and after that the active-low read or write strobe. It waits for the active-low acknowledge from the device. It looks at the synchronised acknowledge once every poll interval, which is about one microsecond. If no acknowledge comes within a limit of about one millisecond, it gives up. The limit, the poll interval and the minimum length of every phase are counted in clock cycles from parameters.

When the wait ends, all selects and strobes go high again and the data lines are driven once more. The block then pulses a done flag and returns the byte seen on the data lines in the last wait cycle. A timeout raises a flag that stays set until the next request is accepted.

Top module: `mbus_cam_master`

## Requirements
- R1: After reset both chip selects, the read strobe and the write strobe are high, both address latch strobes are low, the data lines are driven (output enable 1), req_ready is 1, and rsp_done and rsp_timeout are 0.
- R2: A request is taken only on a cycle where req_valid and req_ready are both 1, and req_ready is 1 only while the bus is idle. A request held valid during a cycle is taken exactly once before rsp_done.
- R3: The first phase drives the low address byte (addr[7:0]) with the low-latch strobe high for exactly HOLD_CYC cycles. The same byte then stays on the lines with the strobe low for HOLD_CYC more cycles.
- R4: The second phase drives the high address byte (addr[15:8]) with the high-latch strobe high for exactly HOLD_CYC cycles. The byte is then held for HOLD_CYC cycles with the strobe low.
- R5: On a read (req_write=0) the output enable is 0 from the data phase to the end of the wait, and never during an address phase. On a write the enable stays 1 and the write byte is driven for as long as the write strobe is low.
- R6: Device index 0 pulls bus_cs_n[0] low and index 1 pulls bus_cs_n[1] low, never both. The chip select is low for HOLD_CYC cycles before the strobe falls, and stays low until the strobe rises.
- R7: A read pulls bus_rd_n low and a write pulls bus_wr_n low, never both. The synchronised acknowledge is examined every POLL_CYC cycles of the wait, so an acknowledged wait lasts a whole multiple of POLL_CYC cycles.
- R8: With no acknowledge, the strobe is released after exactly TIMEOUT_CYC cycles and rsp_timeout is 1 with the done pulse.
- R9: When the wait ends, all selects and strobes are high and the lines are driven again. rsp_done is high for exactly one cycle, and rsp_rdata holds the byte present on bus_d_in in the last wait cycle.
- R10: rsp_timeout stays 1 after a timed-out cycle until the next request is accepted, and is 0 from that acceptance on when that cycle is acknowledged.
- R11: The two address latch strobes are never high together, and neither is high while a read or write strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | Device index selecting the chip select |
| req_addr | input | 16 | Byte address sent in two phases |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured at the end of the wait |
| rsp_timeout | output | 1 | Set by a timed-out cycle, cleared on the next accept |
| bus_d_out | output | 8 | Value driven on the shared lines |
| bus_d_oe | output | 1 | 1 = block drives the lines |
| bus_d_in | input | 8 | Value seen on the shared lines |
| bus_adlo | output | 1 | Low address byte latch strobe, active high |
| bus_adhi | output | 1 | High address byte latch strobe, active high |
| bus_cs_n | output | 2 | Active-low chip selects, one per device |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ack_n | input | 1 | Active-low acknowledge from the device |

## Verification
The assertions assume that the acknowledge input comes back high between cycles, since a level held low across two cycles would end the second wait early. The bench's device model therefore raises the acknowledge as soon as the strobe rises. The assertions also assume that the read data stays on bus_d_in until the strobe rises; the model holds the byte from the moment it acknowledges. Stimulus presents requests only at idle, apart from one scenario that holds req_valid high through a whole cycle on purpose. Acknowledge delays are kept well below the timeout, except in the scenarios that test the timeout.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int BYTE_W  = 8;
  localparam int NUM_DEV = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALO_SET,
    ST_ALO_HOLD,
    ST_AHI_SET,
    ST_AHI_HOLD,
    ST_DATA,
    ST_CSEL,
    ST_WAIT,
    ST_DONE
  } mbus_state_e;

  typedef struct packed {
    logic                  write;
    logic                  dev;
    logic [2*BYTE_W-1:0]   addr;
    logic [BYTE_W-1:0]     wdata;
  } mbus_req_t;

  typedef struct packed {
    logic [BYTE_W-1:0]  dout;
    logic               oe;
    logic               adlo;
    logic               adhi;
    logic [NUM_DEV-1:0] cs_n;
    logic               rd_n;
    logic               wr_n;
  } mbus_pins_t;

  localparam mbus_pins_t PINS_IDLE = '{
    dout: '0, oe: 1'b1, adlo: 1'b0, adhi: 1'b0,
    cs_n: '1, rd_n: 1'b1, wr_n: 1'b1
  };

  // Pin levels wanted for a given phase of the bus cycle.
  function automatic mbus_pins_t pins_for(mbus_state_e st, mbus_req_t rq);
    mbus_pins_t p;
    p = PINS_IDLE;
    case (st)
      ST_ALO_SET: begin
        p.dout = rq.addr[BYTE_W-1:0];
        p.adlo = 1'b1;
      end
      ST_ALO_HOLD: p.dout = rq.addr[BYTE_W-1:0];
      ST_AHI_SET: begin
        p.dout = rq.addr[2*BYTE_W-1:BYTE_W];
        p.adhi = 1'b1;
      end
      ST_AHI_HOLD: p.dout = rq.addr[2*BYTE_W-1:BYTE_W];
      ST_DATA, ST_CSEL, ST_WAIT: begin
        if (rq.write) p.dout = rq.wdata;
        else          p.oe   = 1'b0;
        if (st != ST_DATA) p.cs_n[rq.dev] = 1'b0;
        if (st == ST_WAIT) begin
          if (rq.write) p.wr_n = 1'b0;
          else          p.rd_n = 1'b0;
        end
      end
      default: p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= RST_VAL;
        else     sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= {STAGES{RST_VAL}};
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);

  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LAST);

  // A phase counter never runs past the last cycle of a phase (R3).
  assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/mbus_ack_waiter.sv
module mbus_ack_waiter #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int POLL_CYC    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ack_n_s,
  output logic acked,
  output logic timed_out
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int PW = $clog2(POLL_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] P_LAST = PW'(POLL_CYC - 1);

  logic [TW-1:0] tot_q;
  logic [PW-1:0] poll_q;
  logic          tick;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      tot_q  <= '0;
      poll_q <= '0;
    end else begin
      tot_q  <= tot_q + 1'b1;
      poll_q <= (poll_q == P_LAST) ? '0 : poll_q + 1'b1;
    end
  end

  assign tick      = active && (poll_q == P_LAST);
  assign acked     = tick && !ack_n_s;
  assign timed_out = active && (tot_q == T_LAST);

  // The sequencer leaves the wait when the limit is hit (R8).
  assert_timeout_exit_R8: assert property (@(posedge clk) disable iff (rst)
    timed_out |=> !active);

  // The wait never outlives the limit (R8).
  assert_wait_bound_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> (tot_q < TW'(TIMEOUT_CYC)));

endmodule

// File: rtl/mbus_cam_master.sv
module mbus_cam_master
  import mbus_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int TIMEOUT_US  = 1000,
  parameter int POLL_US     = 1,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_dev,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_done,
  output logic [7:0]  rsp_rdata,
  output logic        rsp_timeout,
  output logic [7:0]  bus_d_out,
  output logic        bus_d_oe,
  input  logic [7:0]  bus_d_in,
  output logic        bus_adlo,
  output logic        bus_adhi,
  output logic [1:0]  bus_cs_n,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  input  logic        bus_ack_n
);

  localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
  localparam int POLL_CYC    = CLK_MHZ * POLL_US;

  mbus_state_e state_q, state_d;
  mbus_req_t   req_q, req_in, req_sel;
  mbus_pins_t  pins_q;
  logic        accept;
  logic        phase_exp;
  logic        ack_s;
  logic        acked, timed_out;
  logic        done_q, tmo_q;
  logic [7:0]  rdata_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_in    = '{write: req_write, dev: req_dev, addr: req_addr, wdata: req_wdata};
  assign req_sel   = accept ? req_in : req_q;

  mbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_ack_n),
    .q   (ack_s)
  );

  mbus_phase_timer #(.HOLD_CYC(HOLD_CYC)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (state_q != state_d),
    .expired (phase_exp)
  );

  mbus_ack_waiter #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_CYC(POLL_CYC)) u_wait (
    .clk       (clk),
    .rst       (rst),
    .active    (state_q == ST_WAIT),
    .ack_n_s   (ack_s),
    .acked     (acked),
    .timed_out (timed_out)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (accept)    state_d = ST_ALO_SET;
      ST_ALO_SET:  if (phase_exp) state_d = ST_ALO_HOLD;
      ST_ALO_HOLD: if (phase_exp) state_d = ST_AHI_SET;
      ST_AHI_SET:  if (phase_exp) state_d = ST_AHI_HOLD;
      ST_AHI_HOLD: if (phase_exp) state_d = ST_DATA;
      ST_DATA:     if (phase_exp) state_d = ST_CSEL;
      ST_CSEL:     if (phase_exp) state_d = ST_WAIT;
      ST_WAIT:     if (acked || timed_out) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      pins_q  <= PINS_IDLE;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d, req_sel);
      done_q  <= (state_d == ST_DONE);
      if (accept) req_q <= req_in;
      if (state_q == ST_WAIT && state_d == ST_DONE) rdata_q <= bus_d_in;
      if (accept) tmo_q <= 1'b0;
      else if (state_q == ST_WAIT && timed_out && !acked) tmo_q <= 1'b1;
    end
  end

  assign bus_d_out   = pins_q.dout;
  assign bus_d_oe    = pins_q.oe;
  assign bus_adlo    = pins_q.adlo;
  assign bus_adhi    = pins_q.adhi;
  assign bus_cs_n    = pins_q.cs_n;
  assign bus_rd_n    = pins_q.rd_n;
  assign bus_wr_n    = pins_q.wr_n;
  assign rsp_done    = done_q;
  assign rsp_rdata   = rdata_q;
  assign rsp_timeout = tmo_q;

  // Ready only while the bus is quiet (R2).
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_cs_n == 2'b11 && bus_rd_n && bus_wr_n));

  // Lines released whenever the read strobe is low (R5).
  assert_read_tristate_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_d_oe);

  // At most one select, and a select already low before a strobe (R6).
  assert_one_cs_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(~bus_cs_n) <= 1);
  assert_cs_first_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) || $fell(bus_wr_n) |-> $past(bus_cs_n) != 2'b11);

  // Read and write strobes are exclusive (R7).
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  // Completion leaves the bus released and the pulse is single (R9).
  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (bus_cs_n == 2'b11 && bus_rd_n && bus_wr_n && bus_d_oe));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // Timeout flag holds until an accept (R10).
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_timeout && !accept) |=> rsp_timeout);

  // Latch strobes exclusive with each other and with a strobe (R11).
  assert_latch_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_adlo && bus_adhi) && !((bus_adlo || bus_adhi) && !(bus_rd_n && bus_wr_n)));

endmodule

// File: tb/mbus_cam_master_tb_top.sv
module mbus_cam_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 2;
  localparam int CLK_MHZ    = 4;
  localparam int TOUT_US    = 16;
  localparam int POLL_US    = 1;
  localparam int SYNC       = 2;
  localparam int TOUT       = CLK_MHZ * TOUT_US;
  localparam int POLL       = CLK_MHZ * POLL_US;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dev = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, rsp_timeout;
  logic [7:0]  rsp_rdata, bus_d_out;
  logic        bus_d_oe, bus_adlo, bus_adhi, bus_rd_n, bus_wr_n;
  logic [1:0]  bus_cs_n;
  logic [7:0]  bus_d_in = 8'h00;
  logic        bus_ack_n = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // device model controls
  bit         ack_en = 0;
  int         ack_dly = 1;
  logic [7:0] rsp_b = 8'h00;
  int         st_age = 0;

  // monitor accumulators
  bit mon_on = 0;
  int n_lo, n_hi, hold_err, excl_err, n_cs0, n_cs1, cs_only, n_rd, n_wr;
  int oe_err, wd_err, n_oe_low, busy_err, n_acc;
  logic [7:0] lo_b, hi_b, exp_wd;
  bit prev_lo = 0, prev_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_cam_master #(
    .CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TOUT_US), .POLL_US(POLL_US),
    .HOLD_CYC(HOLD), .SYNC_STAGES(SYNC)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .bus_d_in(bus_d_in), .bus_adlo(bus_adlo), .bus_adhi(bus_adhi),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ack_n(bus_ack_n)
  );

  // Device model: acknowledge after ack_dly strobe cycles.
  always @(negedge clk) begin
    if (!bus_rd_n || !bus_wr_n) begin
      st_age = st_age + 1;
      if (ack_en && st_age >= ack_dly) begin
        bus_ack_n <= 1'b0;
        bus_d_in  <= rsp_b;
      end
    end else begin
      st_age = 0;
      bus_ack_n <= 1'b1;
    end
  end

  // Pin monitor.
  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_adlo) begin n_lo++; lo_b = bus_d_out; end
      if (bus_adhi) begin n_hi++; hi_b = bus_d_out; end
      if (prev_lo && !bus_adlo && bus_d_out !== lo_b) hold_err++;
      if (prev_hi && !bus_adhi && bus_d_out !== hi_b) hold_err++;
      if ((bus_adlo && bus_adhi) || ((bus_adlo || bus_adhi) && !(bus_rd_n && bus_wr_n)))
        excl_err++;
      if (!bus_d_oe && (bus_adlo || bus_adhi)) oe_err++;
      if (!bus_cs_n[0]) n_cs0++;
      if (!bus_cs_n[1]) n_cs1++;
      if (bus_cs_n != 2'b11 && bus_rd_n && bus_wr_n) cs_only++;
      if (!bus_rd_n) n_rd++;
      if (!bus_wr_n) n_wr++;
      if (!bus_rd_n && bus_d_oe) oe_err++;
      if (!bus_wr_n && (!bus_d_oe || bus_d_out !== exp_wd)) wd_err++;
      if (!bus_d_oe) n_oe_low++;
      if (req_ready && bus_cs_n != 2'b11) busy_err++;
      if (req_valid && req_ready) n_acc++;
      prev_lo = bus_adlo;
      prev_hi = bus_adhi;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    n_lo = 0; n_hi = 0; hold_err = 0; excl_err = 0; n_cs0 = 0; n_cs1 = 0;
    cs_only = 0; n_rd = 0; n_wr = 0; oe_err = 0; wd_err = 0; n_oe_low = 0;
    busy_err = 0; n_acc = 0; prev_lo = 0; prev_hi = 0;
  endtask

  // One full bus cycle with all per-cycle checks.
  task automatic run_txn(input bit wr, input bit dev, input logic [15:0] a,
                         input logic [7:0] wd, input bit aen, input int dly,
                         input logic [7:0] rb, input bit hold_valid);
    int exp_strb, guard, cs_mine, cs_other, strb, other_strb;
    logic [7:0] got_rd, exp_rd;
    bit got_tmo, pins_idle;
    ack_en = aen; ack_dly = dly; rsp_b = rb; exp_wd = wd;
    if (!aen) bus_d_in = rb;
    mon_clear();
    @(negedge clk);
    mon_on = 1;
    req_write = wr; req_dev = dev; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    if (!hold_valid) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!rsp_done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    got_rd = rsp_rdata; got_tmo = rsp_timeout;
    pins_idle = (bus_cs_n == 2'b11) && bus_rd_n && bus_wr_n && bus_d_oe &&
                !bus_adlo && !bus_adhi;
    req_valid = 1'b0;
    @(negedge clk);
    mon_on = 0;
    chk(rsp_done == 1'b0, "R9 done single pulse", rsp_done, 0);
    exp_strb = aen ? ((dly + SYNC + POLL - 1) / POLL) * POLL : TOUT;
    exp_rd   = rb;
    cs_mine  = dev ? n_cs1 : n_cs0;
    cs_other = dev ? n_cs0 : n_cs1;
    strb       = wr ? n_wr : n_rd;
    other_strb = wr ? n_rd : n_wr;
    chk(n_lo == HOLD, "R3 low latch length", n_lo, HOLD);
    chk(lo_b == a[7:0], "R3 low address byte", lo_b, a[7:0]);
    chk(n_hi == HOLD, "R4 high latch length", n_hi, HOLD);
    chk(hi_b == a[15:8], "R4 high address byte", hi_b, a[15:8]);
    chk(hold_err == 0, "R3 R4 byte held after latch", hold_err, 0);
    chk(oe_err == 0, "R5 output enable rule", oe_err, 0);
    if (wr) begin
      chk(wd_err == 0, "R5 write byte driven", wd_err, 0);
      chk(n_oe_low == 0, "R5 write keeps lines driven", n_oe_low, 0);
    end else begin
      chk(n_oe_low == 2*HOLD + n_rd, "R5 read release length", n_oe_low, 2*HOLD + n_rd);
    end
    chk(cs_mine == HOLD + strb, "R6 selected cs length", cs_mine, HOLD + strb);
    chk(cs_other == 0, "R6 other cs stays high", cs_other, 0);
    chk(cs_only == HOLD, "R6 cs leads strobe", cs_only, HOLD);
    chk(other_strb == 0, "R7 wrong strobe unused", other_strb, 0);
    if (aen) begin
      chk(strb == exp_strb, "R7 ack wait length", strb, exp_strb);
      chk(got_tmo == 1'b0, "R7 no timeout on ack", got_tmo, 0);
    end else begin
      chk(strb == TOUT, "R8 timeout wait length", strb, TOUT);
      chk(got_tmo == 1'b1, "R8 timeout flag", got_tmo, 1);
    end
    if (!wr) chk(got_rd == exp_rd, "R9 read byte", got_rd, exp_rd);
    chk(pins_idle, "R9 bus released at done", pins_idle, 1);
    chk(excl_err == 0, "R11 latch strobe exclusion", excl_err, 0);
    chk(busy_err == 0, "R2 ready only idle", busy_err, 0);
    chk(n_acc == 1, "R2 single accept", n_acc, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_cs_n == 2'b11, "R1 selects high", bus_cs_n, 3);
    chk(bus_rd_n && bus_wr_n, "R1 strobes high", {bus_rd_n, bus_wr_n}, 3);
    chk(!bus_adlo && !bus_adhi, "R1 latch strobes low", {bus_adlo, bus_adhi}, 0);
    chk(bus_d_oe == 1'b1, "R1 lines driven", bus_d_oe, 1);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(!rsp_done && !rsp_timeout, "R1 response clear", {rsp_done, rsp_timeout}, 0);
  endtask

  task automatic t_read_dev0();
    run_txn(1'b0, 1'b0, 16'hA55A, 8'h00, 1'b1, 1, 8'hC3, 1'b0);
    run_txn(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 6, 8'h00, 1'b0);
  endtask

  task automatic t_write_dev1();
    run_txn(1'b1, 1'b1, 16'hFFFF, 8'h5A, 1'b1, 3, 8'h00, 1'b0);
    run_txn(1'b1, 1'b1, 16'h1234, 8'hFF, 1'b1, 9, 8'h00, 1'b0);
  endtask

  task automatic t_mixed();
    run_txn(1'b0, 1'b1, 16'h8001, 8'h00, 1'b1, 2, 8'h96, 1'b0);
    run_txn(1'b1, 1'b0, 16'h7FFE, 8'h01, 1'b1, 4, 8'h00, 1'b0);
  endtask

  task automatic t_busy_hold();
    // R2: valid kept high through the whole cycle
    run_txn(1'b0, 1'b0, 16'h2468, 8'h00, 1'b1, 5, 8'h7E, 1'b1);
  endtask

  task automatic t_timeout_sticky();
    run_txn(1'b0, 1'b1, 16'hBEEF, 8'h00, 1'b0, 1, 8'h3C, 1'b0);
    repeat (5) @(negedge clk);
    chk(rsp_timeout == 1'b1, "R10 timeout flag holds while idle", rsp_timeout, 1);
    run_txn(1'b1, 1'b0, 16'h0F0F, 8'hA0, 1'b0, 1, 8'h11, 1'b0);
    chk(rsp_timeout == 1'b1, "R10 flag after second timeout", rsp_timeout, 1);
    // an acknowledged cycle clears it at accept
    @(negedge clk);
    req_write = 1'b0; req_dev = 1'b0; req_addr = 16'h0101; req_valid = 1'b1;
    ack_en = 1; ack_dly = 1; rsp_b = 8'h44;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_timeout == 1'b0, "R10 flag cleared on accept", rsp_timeout, 0);
    while (!rsp_done) @(negedge clk);
    chk(rsp_timeout == 1'b0, "R10 flag low after acked cycle", rsp_timeout, 0);
    chk(rsp_rdata == 8'h44, "R9 read byte after recovery", rsp_rdata, 8'h44);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_dev0();
    t_write_dev1();
    t_mixed();
    t_busy_hold();
    t_timeout_sticky();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule